// File: doc/BRIEF.md
# Bus Cycle Command Timing Controller

This block follows the local bus cycles of a processor and produces the active-low read and write command strobes for each cycle. A cycle begins when the processor's two status lines carry a read or write code. The controller then spends one status clock (Ts) and enters command clocks (Tc). It stays in Tc until the shared, clock-synchronous ready input is seen active. The processor sees the same ready, so both sides end the cycle on the same edge. When the processor has the next cycle's status ready on that edge, a new Ts follows at once and the bus alternates Ts and Tc with no idle clock.

A command-hold input lets the system push back the leading edge of the strobe by whole clocks, and the amount can differ from cycle to cycle. Tc is never shown outside the block: the strobes are the only outward sign of the command phase. A cycle-active output is high through Ts and every Tc. All state is reset synchronously.

Top module: `bus_cmd_timer`

## Requirements
- R1: While the synchronous reset is high, and in the clock after it is released, cycleActive is 0 and rdCmdN and wrCmdN are both 1.
- R2: In idle, a status code sampled at a rising edge starts a cycle if it is 2'b01 (read) or 2'b10 (write). The next clock is Ts: cycleActive is 1 and both strobes are high. The codes 2'b00 and 2'b11 leave the block idle.
- R3: Ts lasts exactly one clock and is always followed by Tc.
- R4: Tc repeats while rdyIn is sampled low. The Tc in which rdyIn is sampled high is the last one, and any asserted strobe goes high on the edge that ends it.
- R5: If a valid status code is sampled on the edge that ends the last Tc, the next clock is Ts, with no idle clock between. Otherwise the block returns to idle and cycleActive falls.
- R6: Status codes sampled during Ts, or during a Tc that is not the last one, have no effect on the state or on the direction of the current cycle.
- R7: cmdHold is sampled on the edge that ends Ts and on every Tc edge until the strobe asserts. Each sample taken high delays the strobe's falling edge by one clock. With cmdHold low at the end of Ts, the strobe is low from the first Tc onward.
- R8: Once a strobe is low, cmdHold is ignored for the rest of that cycle.
- R9: A read cycle drives only rdCmdN low and a write cycle drives only wrCmdN low. The two strobes are never low together.
- R10: rdyIn is ignored while the block is idle or in Ts.
- R11: If rdyIn ends a cycle while the strobe is still held off, that cycle ends with no strobe asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busStatus | input | 2 | Processor status: 01 read, 10 write, 00/11 no cycle |
| cmdHold | input | 1 | Holds off the command strobe's leading edge while high |
| rdyIn | input | 1 | Synchronous ready, active high; marks the last Tc |
| rdCmdN | output | 1 | Read command strobe, active low |
| wrCmdN | output | 1 | Write command strobe, active low |
| cycleActive | output | 1 | High during Ts and every Tc |

## Verification
The hardest cycle is the last Tc. In that clock, ending the current cycle (strobe release, R4) and starting the next (new Ts and a new direction, R5) happen on the same edge, and a still-pending hold (R11) may be dropped at the same time. The bench provokes this with back-to-back read/write pairs that present the new status code together with rdyIn. Some of these pairs also keep cmdHold high across the boundary. A behavioural reference model, compared on every clock, judges the result: the old strobe must go high, the opposite strobe must not assert in Ts, and cycleActive must not dip.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

  localparam int STATUS_W = 2;
  localparam logic [STATUS_W-1:0] ST_READ  = 2'b01;
  localparam logic [STATUS_W-1:0] ST_WRITE = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TS   = 2'd1,
    PH_TC   = 2'd2
  } phase_t;

  // strobes from the control FSM to the command datapath
  typedef struct packed {
    logic latchDir;  // a new cycle starts on this edge: capture direction
    logic tsEnd;     // this edge ends Ts
    logic tcOpen;    // Tc that continues past this edge
    logic tcEnd;     // last Tc ends on this edge
  } cmd_ctl_t;

  function automatic logic statusStarts(input logic [STATUS_W-1:0] s);
    return (s == ST_READ) || (s == ST_WRITE);
  endfunction

endpackage

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                rdyIn,
  output cmd_ctl_t            ctl,
  output logic                cycleActive
);

  phase_t phase, phaseNext;
  logic   startSeen;

  assign startSeen = statusStarts(busStatus);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (startSeen) phaseNext = PH_TS;
      PH_TS:   phaseNext = PH_TC;
      PH_TC:   if (rdyIn) phaseNext = startSeen ? PH_TS : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    ctl.latchDir = (phaseNext == PH_TS);
    ctl.tsEnd    = (phase == PH_TS);
    ctl.tcOpen   = (phase == PH_TC) && !rdyIn;
    ctl.tcEnd    = (phase == PH_TC) && rdyIn;
  end

  assign cycleActive = (phase != PH_IDLE);

  // Ts is one clock, then Tc
  p_ts_to_tc_r3: assert property (@(posedge clk) disable iff (rst)
    phase == PH_TS |=> phase == PH_TC);

  // Tc holds without ready
  p_tc_waits_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TC && !rdyIn) |=> phase == PH_TC);

  // back-to-back start with no idle clock
  p_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TC && rdyIn && startSeen) |=> phase == PH_TS);

  // ready ignored in idle
  p_idle_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !startSeen) |=> phase == PH_IDLE);

endmodule

// File: rtl/bus_cmd_datapath.sv
module bus_cmd_datapath
  import bus_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                cmdHold,
  input  cmd_ctl_t            ctl,
  output logic                rdCmdN,
  output logic                wrCmdN
);

  logic isWrite;
  logic cmdOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      isWrite <= 1'b0;
    end else if (ctl.latchDir) begin
      isWrite <= (busStatus == ST_WRITE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdOn <= 1'b0;
    end else if (ctl.tsEnd) begin
      cmdOn <= !cmdHold;
    end else if (ctl.tcOpen) begin
      if (!cmdOn) cmdOn <= !cmdHold;
    end else if (ctl.tcEnd) begin
      cmdOn <= 1'b0;
    end
  end

  assign rdCmdN = !(cmdOn && !isWrite);
  assign wrCmdN = !(cmdOn && isWrite);

  // strobe released on the terminating edge
  p_strobe_release_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.tcEnd |=> (rdCmdN && wrCmdN));

  // asserted strobe is sticky within the cycle
  p_strobe_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.tcOpen && cmdOn) |=> cmdOn);

  // held-off strobe stays off
  p_hold_delays_r7: assert property (@(posedge clk) disable iff (rst)
    ((ctl.tsEnd || (ctl.tcOpen && !cmdOn)) && cmdHold) |=> (rdCmdN && wrCmdN));

  // direction frozen through Tc
  p_dir_stable_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.tcOpen |=> $stable(isWrite));

endmodule

// File: rtl/bus_cmd_timer.sv
module bus_cmd_timer
  import bus_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] busStatus,
  input  logic       cmdHold,
  input  logic       rdyIn,
  output logic       rdCmdN,
  output logic       wrCmdN,
  output logic       cycleActive
);

  cmd_ctl_t ctl;

  bus_cmd_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .busStatus   (busStatus),
    .rdyIn       (rdyIn),
    .ctl         (ctl),
    .cycleActive (cycleActive)
  );

  bus_cmd_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .busStatus (busStatus),
    .cmdHold   (cmdHold),
    .ctl       (ctl),
    .rdCmdN    (rdCmdN),
    .wrCmdN    (wrCmdN)
  );

  // never both strobes
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(!rdCmdN && !wrCmdN));

  // strobe only inside an active cycle
  p_strobe_in_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (!rdCmdN || !wrCmdN) |-> cycleActive);

endmodule

// File: tb/bus_cmd_timer_test.sv
module bus_cmd_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] busStatus = 2'b11;
  logic       cmdHold = 1'b0;
  logic       rdyIn = 1'b0;
  logic       rdCmdN, wrCmdN, cycleActive;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  bus_cmd_timer uut (
    .clk(clk), .rst(rst), .busStatus(busStatus), .cmdHold(cmdHold),
    .rdyIn(rdyIn), .rdCmdN(rdCmdN), .wrCmdN(wrCmdN), .cycleActive(cycleActive)
  );

  // behavioural reference: 0 idle, 1 status clock, 2 command clock
  int mPhase = 0;
  bit mWrite = 0;
  bit mCmd = 0;

  function automatic bit validCode(input logic [1:0] s);
    return s == 2'b01 || s == 2'b10;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mWrite = 0; mCmd = 0;
    end else begin
      case (mPhase)
        0: if (validCode(busStatus)) begin mPhase = 1; mWrite = (busStatus == 2'b10); end
        1: begin mCmd = !cmdHold; mPhase = 2; end
        default: begin
          if (rdyIn) begin
            mCmd = 0;
            if (validCode(busStatus)) begin mPhase = 1; mWrite = (busStatus == 2'b10); end
            else mPhase = 0;
          end else if (!mCmd) begin
            mCmd = !cmdHold;
          end
        end
      endcase
    end
  end

  task automatic compare();
    bit eRd, eWr, eAct;
    eRd = !(mCmd && !mWrite);
    eWr = !(mCmd && mWrite);
    eAct = (mPhase != 0);
    total++;
    if (rdCmdN !== eRd || wrCmdN !== eWr || cycleActive !== eAct) begin
      bad++;
      $display("FAIL %s t=%0t rd/wr/act actual=%b%b%b expected=%b%b%b",
               curReq, $time, rdCmdN, wrCmdN, cycleActive, eRd, eWr, eAct);
    end
  endtask

  // drive one clock of inputs, then compare after the edge
  task automatic cyc(input logic [1:0] st, input logic hold, input logic rdy);
    busStatus = st; cmdHold = hold; rdyIn = rdy;
    @(negedge clk);
    compare();
  endtask

  task automatic expectPins(input bit eRd, input bit eWr, input bit eAct);
    total++;
    if (rdCmdN !== eRd || wrCmdN !== eWr || cycleActive !== eAct) begin
      bad++;
      $display("FAIL %s directed actual=%b%b%b expected=%b%b%b",
               curReq, rdCmdN, wrCmdN, cycleActive, eRd, eWr, eAct);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    curReq = "R1";
    @(negedge clk); compare();
    cyc(2'b01, 1'b0, 1'b1);   // valid code under reset ignored
    expectPins(1, 1, 0);
    rst = 1'b0;
    cyc(2'b11, 1'b0, 1'b0);
    expectPins(1, 1, 0);

    // R2 idle codes
    curReq = "R2";
    cyc(2'b00, 1'b0, 1'b0);
    cyc(2'b11, 1'b0, 1'b0);
    expectPins(1, 1, 0);
    // R10 ready in idle ignored
    curReq = "R10";
    cyc(2'b00, 1'b0, 1'b1);
    expectPins(1, 1, 0);

    // R2/R3 read start; R6 status ignored in Ts; R10 ready in Ts ignored
    curReq = "R2";
    cyc(2'b01, 1'b0, 1'b0);            // now in Ts
    expectPins(1, 1, 1);
    curReq = "R3";
    cyc(2'b10, 1'b0, 1'b1);            // ends Ts: ready and status ignored
    expectPins(0, 1, 1);               // first Tc, read strobe low
    curReq = "R6";
    cyc(2'b10, 1'b0, 1'b0);            // status during open Tc ignored
    expectPins(0, 1, 1);
    curReq = "R4";
    cyc(2'b11, 1'b0, 1'b1);            // last Tc -> idle
    expectPins(1, 1, 0);

    // R7 write with two hold clocks
    curReq = "R7";
    cyc(2'b10, 1'b0, 1'b0);            // Ts
    cyc(2'b11, 1'b1, 1'b0);            // held at Ts end
    expectPins(1, 1, 1);
    cyc(2'b11, 1'b1, 1'b0);            // held again
    expectPins(1, 1, 1);
    cyc(2'b11, 1'b0, 1'b0);            // released
    expectPins(1, 0, 1);
    // R8 hold ignored once strobe low
    curReq = "R8";
    cyc(2'b11, 1'b1, 1'b0);
    expectPins(1, 0, 1);
    // R5 back-to-back: write ends, read starts on same edge
    curReq = "R5";
    cyc(2'b01, 1'b1, 1'b1);
    expectPins(1, 1, 1);               // Ts of new read
    curReq = "R9";
    cyc(2'b11, 1'b0, 1'b0);
    expectPins(0, 1, 1);
    curReq = "R5";
    cyc(2'b10, 1'b0, 1'b1);            // read ends, write starts
    expectPins(1, 1, 1);

    // R11 ready while held: no strobe at all
    curReq = "R11";
    cyc(2'b11, 1'b1, 1'b0);            // Ts end, held
    expectPins(1, 1, 1);
    cyc(2'b11, 1'b1, 1'b1);            // last Tc, never asserted
    expectPins(1, 1, 0);

    // mixed traffic against the model
    curReq = "R9";
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      if (i % 500 == 250) rst = 1'b1;
      else rst = 1'b0;
      cyc(s, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0));
    end
    rst = 1'b0;
    curReq = "R4";
    for (int i = 0; i < 400; i++) begin
      cyc(2'($urandom_range(1, 2)), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule